// File: doc/BRIEF.md
# Error Header Log with Pending-Record Queue

This block keeps the error log state of a link endpoint: a pointer to the uncorrectable status bit of the error currently logged, a four-word header log and a four-word prefix log. It also owns the uncorrectable error status register. Error signaling logic hands it one record per cycle at most. Each record carries a one-hot status, four header words, four prefix words and two validity flags. Software clears status bits with write-1-to-clear writes.

Multiple-header recording is optional. When it is enabled, an error that arrives while the logged error's status bit is still set is not written over the log. It waits in a FIFO of depth `QDEPTH` instead. When software clears the logged error's status bit, the oldest waiting record moves into the log. The status bits of every record that was waiting at that moment are set again, so software sees each one in turn. A record that finds the FIFO full is dropped, and the block raises a one-cycle overflow pulse.

Every output is registered. An input applied in cycle n shows at the outputs after the clock edge that ends cycle n.

Top module: `hl_hdr_log`

## Requirements
- R1: After reset the status, the pointer, both logs, the prefix-present flag, the recording enable and the overflow output are all zero, and the queue is empty.
- R2: A log request sets the status bit given by its one-hot status (bit k means error index k). When the record goes to the log, the pointer becomes k.
- R3: Header words are stored in the log in big-endian order. Log word i is input word i (bits 32*i+31..32*i) with its four bytes reversed, so input bits 7:0 become log bits 31:24. A record whose header-valid flag is low leaves the header log all zero.
- R4: Prefix words are stored, byte-reversed like the header, only when the record's prefix-valid flag and the prefix capability input are both high. The prefix-present flag is then set. Otherwise the prefix log is zeroed and the flag is cleared.
- R5: With recording disabled, every new record overwrites the log.
- R6: With recording enabled and the status bit under the pointer still set, a new record is queued and the log does not change.
- R7: A record that would be queued while the queue holds QDEPTH records is dropped, and overflow_o is high for exactly the following cycle. Its status bit is still set.
- R8: mhr_cap_o is 1 exactly when QDEPTH > 0. The enable bit takes the written value only in that case.
- R9: A status write that clears the bit under the pointer, with recording disabled or the queue empty, clears the pointer, the prefix flag and both logs.
- R10: A status write that clears the bit under the pointer, with recording enabled and records waiting, loads the oldest waiting record into the log. The status bits of all records waiting before the write are set again.
- R11: A status write that leaves the bit under the pointer set, with recording enabled, clears the written bits. The exception is a bit that belongs to a waiting record: that bit stays set.
- R12: A status write that leaves the bit under the pointer set, with recording disabled, empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| log_req_i | input | 1 | Error record valid this cycle |
| log_status_i | input | 32 | One-hot uncorrectable status of the record |
| log_hdr_i | input | 128 | Four header words, word i in bits 32*i+31..32*i |
| log_pfx_i | input | 128 | Four prefix words, same layout |
| log_hdr_vld_i | input | 1 | Header words are valid |
| log_pfx_vld_i | input | 1 | Record carries a prefix |
| e2e_pfx_cap_i | input | 1 | Prefix logging capability |
| en_wr_i | input | 1 | Write strobe for the recording enable |
| en_wdata_i | input | 1 | Value written to the recording enable |
| sts_wr_i | input | 1 | Write strobe for the status register |
| sts_w1c_i | input | 32 | Write-1-to-clear mask |
| uncor_sts_o | output | 32 | Uncorrectable status register |
| fep_o | output | 5 | Index of the logged error's status bit |
| hdr_log_o | output | 128 | Header log |
| pfx_log_o | output | 128 | Prefix log |
| pfx_present_o | output | 1 | Prefix log holds a valid prefix |
| mhr_cap_o | output | 1 | Multiple-header recording capability |
| mhr_en_o | output | 1 | Multiple-header recording enable |
| overflow_o | output | 1 | One-cycle pulse: a record was dropped on a full queue |

## Verification
The assertions assume three things about the inputs. At most one of a log request, a status write and an enable write arrives in any cycle. The status of every log request has exactly one bit set. The queue is never asked to push while full or pop while empty, which holds if the control decodes correctly. The stimulus applies one operation per cycle through separate driver tasks, and every index it uses is a single shifted bit. The queue is filled past its depth and drained back through clears of the logged bit. This exercises the overflow boundary and the order in which records leave the queue.

// File: rtl/hl_pkg.sv
package hl_pkg;
  localparam int HL_ST_W    = 32;
  localparam int HL_WORD_W  = 32;
  localparam int HL_NWORDS  = 4;
  localparam int HL_IDX_W   = $clog2(HL_ST_W);
  localparam int HL_LOG_W   = HL_WORD_W * HL_NWORDS;

  typedef struct packed {
    logic [HL_IDX_W-1:0] idx;
    logic [HL_LOG_W-1:0] hdr;
    logic [HL_LOG_W-1:0] pfx;
    logic                hdr_vld;
    logic                pfx_vld;
  } hl_rec_t;

  function automatic logic [HL_WORD_W-1:0] hl_bswap(input logic [HL_WORD_W-1:0] w);
    logic [HL_WORD_W-1:0] r;
    for (int b = 0; b < HL_WORD_W/8; b++) r[8*b +: 8] = w[HL_WORD_W-8-8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/hl_idx_enc.sv
module hl_idx_enc #(
  parameter int W     = 32,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     oh_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < W; k++) if (oh_i[k]) idx_o = idx_o | IDX_W'(k);
  end
endmodule

// File: rtl/hl_rec_fifo.sv
module hl_rec_fifo import hl_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic               flush_i,
  input  hl_rec_t            din_i,
  output hl_rec_t            head_o,
  output logic               full_o,
  output logic               empty_o,
  output logic [HL_ST_W-1:0] sts_or_o
);
  hl_rec_t    ent_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = ent_q[0];

  always_comb begin
    sts_or_o = '0;
    for (int k = 0; k < DEPTH; k++)
      if (CNT_W'(k) < cnt_q) sts_or_o = sts_or_o | (HL_ST_W'(1) << ent_q[k].idx);
  end

  // shift queue: entry 0 is always the oldest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else if (pop_i) begin
      for (int k = 0; k < DEPTH-1; k++) ent_q[k] <= ent_q[k+1];
      cnt_q <= cnt_q - 1'b1;
    end else if (push_i) begin
      for (int k = 0; k < DEPTH; k++) if (CNT_W'(k) == cnt_q) ent_q[k] <= din_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_no_push_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_pop_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/hl_log_store.sv
module hl_log_store import hl_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                clear_i,
  input  hl_rec_t             rec_i,
  input  logic                pfx_cap_i,
  output logic [HL_IDX_W-1:0] fep_o,
  output logic [HL_LOG_W-1:0] hdr_o,
  output logic [HL_LOG_W-1:0] pfx_o,
  output logic                pfx_present_o
);
  logic [HL_LOG_W-1:0] hdr_sw, pfx_sw;
  logic                pfx_take;

  assign pfx_take = rec_i.pfx_vld && pfx_cap_i;

  for (genvar i = 0; i < HL_NWORDS; i++) begin : g_word
    assign hdr_sw[HL_WORD_W*i +: HL_WORD_W] = hl_bswap(rec_i.hdr[HL_WORD_W*i +: HL_WORD_W]);
    assign pfx_sw[HL_WORD_W*i +: HL_WORD_W] = hl_bswap(rec_i.pfx[HL_WORD_W*i +: HL_WORD_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fep_o <= '0; hdr_o <= '0; pfx_o <= '0; pfx_present_o <= 1'b0;
    end else if (clear_i) begin
      fep_o <= '0; hdr_o <= '0; pfx_o <= '0; pfx_present_o <= 1'b0;
    end else if (load_i) begin
      fep_o         <= rec_i.idx;
      hdr_o         <= rec_i.hdr_vld ? hdr_sw : '0;
      pfx_o         <= pfx_take ? pfx_sw : '0;
      pfx_present_o <= pfx_take;
    end
  end

  p_clear_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (fep_o == '0) && !pfx_present_o && (hdr_o == '0) && (pfx_o == '0));
  p_pfx_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i && !pfx_cap_i) |=> !pfx_present_o && (pfx_o == '0));
endmodule

// File: rtl/hl_hdr_log.sv
module hl_hdr_log import hl_pkg::*; #(
  parameter int QDEPTH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                log_req_i,
  input  logic [HL_ST_W-1:0]  log_status_i,
  input  logic [HL_LOG_W-1:0] log_hdr_i,
  input  logic [HL_LOG_W-1:0] log_pfx_i,
  input  logic                log_hdr_vld_i,
  input  logic                log_pfx_vld_i,
  input  logic                e2e_pfx_cap_i,
  input  logic                en_wr_i,
  input  logic                en_wdata_i,
  input  logic                sts_wr_i,
  input  logic [HL_ST_W-1:0]  sts_w1c_i,
  output logic [HL_ST_W-1:0]  uncor_sts_o,
  output logic [HL_IDX_W-1:0] fep_o,
  output logic [HL_LOG_W-1:0] hdr_log_o,
  output logic [HL_LOG_W-1:0] pfx_log_o,
  output logic                pfx_present_o,
  output logic                mhr_cap_o,
  output logic                mhr_en_o,
  output logic                overflow_o
);
  localparam bit HAS_Q = (QDEPTH > 0);

  logic [HL_ST_W-1:0]  sts_q, sts_after, q_or;
  logic                mhr_en_q, ovf_q;
  logic [HL_IDX_W-1:0] new_idx;
  hl_rec_t             new_rec, head_rec, load_rec;
  logic                q_full, q_empty;
  logic                to_queue, push, pop, flush, load, clear_log, first_gone;

  hl_idx_enc #(.W(HL_ST_W)) u_enc (.oh_i(log_status_i), .idx_o(new_idx));

  assign new_rec = '{idx: new_idx, hdr: log_hdr_i, pfx: log_pfx_i,
                     hdr_vld: log_hdr_vld_i, pfx_vld: log_pfx_vld_i};

  // queue only while the logged error is still unacknowledged
  assign to_queue   = log_req_i && mhr_en_q && sts_q[fep_o];
  assign push       = to_queue && !q_full;
  assign sts_after  = sts_q & ~sts_w1c_i;
  assign first_gone = sts_wr_i && !sts_after[fep_o];
  assign pop        = first_gone && mhr_en_q && !q_empty;
  assign clear_log  = first_gone && !pop;
  assign flush      = sts_wr_i && sts_after[fep_o] && !mhr_en_q;
  assign load       = (log_req_i && !to_queue) || pop;
  assign load_rec   = pop ? head_rec : new_rec;

  if (HAS_Q) begin : g_queue
    hl_rec_fifo #(.DEPTH(QDEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_i(push), .pop_i(pop), .flush_i(flush), .din_i(new_rec),
      .head_o(head_rec), .full_o(q_full), .empty_o(q_empty), .sts_or_o(q_or)
    );
  end else begin : g_noqueue
    assign head_rec = '0;
    assign q_full   = 1'b1;
    assign q_empty  = 1'b1;
    assign q_or     = '0;
  end

  hl_log_store u_log (
    .clk_i, .rst_ni,
    .load_i(load), .clear_i(clear_log), .rec_i(load_rec), .pfx_cap_i(e2e_pfx_cap_i),
    .fep_o(fep_o), .hdr_o(hdr_log_o), .pfx_o(pfx_log_o), .pfx_present_o(pfx_present_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q    <= '0;
      mhr_en_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      ovf_q <= to_queue && q_full;
      if (log_req_i)     sts_q <= sts_q | log_status_i;
      else if (sts_wr_i) sts_q <= sts_after | (mhr_en_q ? q_or : '0);
      if (en_wr_i && HAS_Q) mhr_en_q <= en_wdata_i;
    end
  end

  assign uncor_sts_o = sts_q;
  assign mhr_cap_o   = HAS_Q;
  assign mhr_en_o    = mhr_en_q;
  assign overflow_o  = ovf_q;

  p_excl_inputs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({log_req_i, sts_wr_i, en_wr_i}));
  p_onehot_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_req_i |-> $countones(log_status_i) == 1);
  p_ovf_when_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> q_full);
  p_en_needs_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mhr_en_o |-> mhr_cap_o);
  p_queued_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr_i && mhr_en_q) |=> ((uncor_sts_o & $past(q_or)) == $past(q_or)));
endmodule

// File: tb/sim_hl_hdr_log.sv
module sim_hl_hdr_log;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 4;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic         log_req = 0, hdr_vld = 0, pfx_vld = 0, pfx_cap = 0;
  logic [31:0]  log_status = '0, w1c = '0;
  logic [127:0] hdr_in = '0, pfx_in = '0;
  logic         en_wr = 0, en_wdata = 0, sts_wr = 0;
  logic [31:0]  sts_o;
  logic [4:0]   fep_o;
  logic [127:0] hdr_o, pfx_o;
  logic         pres_o, cap_o, en_o, ovf_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  hl_hdr_log #(.QDEPTH(QD)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .log_req_i(log_req), .log_status_i(log_status), .log_hdr_i(hdr_in), .log_pfx_i(pfx_in),
    .log_hdr_vld_i(hdr_vld), .log_pfx_vld_i(pfx_vld), .e2e_pfx_cap_i(pfx_cap),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata), .sts_wr_i(sts_wr), .sts_w1c_i(w1c),
    .uncor_sts_o(sts_o), .fep_o(fep_o), .hdr_log_o(hdr_o), .pfx_log_o(pfx_o),
    .pfx_present_o(pres_o), .mhr_cap_o(cap_o), .mhr_en_o(en_o), .overflow_o(ovf_o)
  );

  typedef struct {
    int idx; logic [127:0] h; logic [127:0] p; logic hv; logic pv;
  } rec_t;
  typedef struct {
    logic [31:0] sts; int fep; logic [127:0] h; logic [127:0] p;
    logic pres; logic cap; logic en; logic ovf;
  } snap_t;

  // reference model state
  logic [31:0]  e_sts = '0;
  int           e_fep = 0;
  logic [127:0] e_h = '0, e_p = '0;
  logic         e_pres = 0, e_en = 0, e_ovf = 0;
  rec_t         mq[$];

  snap_t sb[$];
  string sb_tag[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [127:0] swap4(input logic [127:0] v);
    logic [127:0] r;
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++) r[32*w + 8*b +: 8] = v[32*w + 24 - 8*b +: 8];
    return r;
  endfunction

  task automatic m_load(input rec_t r);
    e_fep  = r.idx;
    e_h    = r.hv ? swap4(r.h) : '0;
    e_pres = r.pv && pfx_cap;
    e_p    = e_pres ? swap4(r.p) : '0;
  endtask

  task automatic expect_now(input string tag);
    snap_t s;
    s.sts = e_sts; s.fep = e_fep; s.h = e_h; s.p = e_p;
    s.pres = e_pres; s.cap = 1'b1; s.en = e_en; s.ovf = e_ovf;
    sb.push_back(s);
    sb_tag.push_back(tag);
  endtask

  task automatic do_log(input int idx, input logic [127:0] h, input logic [127:0] p,
                        input logic hv, input logic pv, input string tag);
    rec_t r;
    @(negedge clk);
    log_req = 1; log_status = 32'h1 << idx; hdr_in = h; pfx_in = p; hdr_vld = hv; pfx_vld = pv;
    @(posedge clk); #1;
    log_req = 0;
    r.idx = idx; r.h = h; r.p = p; r.hv = hv; r.pv = pv;
    e_ovf = 0;
    if (e_en && e_sts[e_fep]) begin
      if (mq.size() == QD) e_ovf = 1;
      else mq.push_back(r);
    end else m_load(r);
    e_sts = e_sts | (32'h1 << idx);
    expect_now(tag);
  endtask

  task automatic do_w1c(input logic [31:0] m, input string tag);
    logic [31:0] s, qor;
    rec_t r;
    @(negedge clk);
    sts_wr = 1; w1c = m;
    @(posedge clk); #1;
    sts_wr = 0;
    e_ovf = 0;
    s = e_sts & ~m;
    qor = '0;
    foreach (mq[i]) qor = qor | (32'h1 << mq[i].idx);
    if (!s[e_fep]) begin
      if (!e_en || mq.size() == 0) begin
        e_fep = 0; e_h = '0; e_p = '0; e_pres = 0;
        e_sts = s | (e_en ? qor : '0);
      end else begin
        e_sts = s | qor;
        r = mq.pop_front();
        m_load(r);
      end
    end else if (e_en) e_sts = s | qor;
    else begin
      mq.delete();
      e_sts = s;
    end
    expect_now(tag);
  endtask

  task automatic do_en(input logic v, input string tag);
    @(negedge clk);
    en_wr = 1; en_wdata = v;
    @(posedge clk); #1;
    en_wr = 0;
    e_ovf = 0;
    e_en = v;
    expect_now(tag);
  endtask

  // monitor: compare one expected snapshot per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      snap_t s;
      string t;
      s = sb.pop_front();
      t = sb_tag.pop_front();
      checks++;
      if (sts_o !== s.sts || int'(fep_o) != s.fep || hdr_o !== s.h || pfx_o !== s.p ||
          pres_o !== s.pres || cap_o !== s.cap || en_o !== s.en || ovf_o !== s.ovf) begin
        errors++;
        $display("FAIL %s: act sts=%h fep=%0d hdr=%h pfx=%h pres=%b cap=%b en=%b ovf=%b | exp sts=%h fep=%0d hdr=%h pfx=%h pres=%b cap=%b en=%b ovf=%b",
                 t, sts_o, fep_o, hdr_o, pfx_o, pres_o, cap_o, en_o, ovf_o,
                 s.sts, s.fep, s.h, s.p, s.pres, s.cap, s.en, s.ovf);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [127:0] H_A = 128'h33221100_77665544_BBAA9988_FFEEDDCC;
  localparam logic [127:0] P_A = 128'h0F0E0D0C_0B0A0908_07060504_03020100;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(posedge clk); #1;
    expect_now("R1 reset state");
    pfx_cap = 1;
    do_log(4, H_A, P_A, 1, 1, "R2 R3 R4 first record logged, prefix kept");
    do_log(12, H_A ^ 128'h1, P_A, 0, 0, "R5 R3 overwrite with invalid header");
    pfx_cap = 0;
    do_log(5, H_A, P_A, 1, 1, "R4 prefix dropped without capability");
    do_w1c(32'h0000_0020, "R9 first bit cleared, recording off");
    do_w1c(32'hFFFF_FFFF, "R9 clear all");
    do_en(1, "R8 enable writable with queue");
    pfx_cap = 1;
    do_log(1, 128'h1111, 128'h2222, 1, 1, "R2 load with recording on");
    do_log(2, 128'hA2, 128'hB2, 1, 1, "R6 queued, log unchanged");
    do_log(3, 128'hA3, 128'hB3, 1, 0, "R6 queued second");
    do_log(7, 128'hA7, 128'hB7, 0, 1, "R6 queued third");
    do_log(9, 128'hA9, 128'hB9, 1, 1, "R6 queued fourth, queue full");
    do_log(10, 128'hAA, 128'hBA, 1, 1, "R7 overflow on full queue");
    do_w1c(32'h0000_0004, "R11 queued bit re-asserted, overflow gone");
    do_w1c(32'h0000_0002, "R10 pop oldest into log");
    do_w1c(32'hFFFF_FFFF, "R10 second pop reasserts queued bits");
    do_en(0, "R8 enable cleared");
    do_w1c(32'h0000_0001, "R12 flush with recording off");
    do_en(1, "R8 enable set again");
    do_w1c(32'h0000_0008, "R12 queue flushed so clear empties log");
    do_log(20, H_A, P_A, 1, 1, "R2 log after flush");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule